// File: doc/BRIEF.md
# Display Interrupt Status and Dispatch Controller

This block gathers the interrupt sources of a two-head display engine into two status words. It raises a single interrupt request line toward the host and names the one source the host should service next. The sources are five channel error events, five channel completion events, a vertical blank event per head, and a supervisor request that arrives in one of three phases. A channel error also leaves behind a per-channel error record, which holds the offending method address, an error type and an error code, plus a separate data word.

The host uses a plain register port: it writes with `reg_we`, and reads through a combinational `reg_rdata` that decodes `reg_addr`. Status bits are cleared by writing ones to them. When a set and a clear of the same bit land in the same cycle, the set is kept. A service selector picks the next source by fixed priority. Channel errors come first, lowest channel first. Completion events follow, then vertical blank, then the supervisor phase. The host clears what it has handled and reads the selector again.

Top module: `disp_irq_ctrl`

## Requirements
- R1: After reset, every status bit, both enable words and every error record and data word read 0, and `irq` and `svc_valid` are low.
- R2: A pulse on `ch_err[c]` sets status word 0 (address 0) bit 16+c, and a pulse on `ch_done[c]` sets bit c. Each such bit stays set until the host writes a 1 at that position. Writing 0 at that position leaves the bit unchanged.
- R3: If a source event and a write-one-to-clear of its status bit happen in the same cycle, the bit stays set.
- R4: An error on channel c is captured into record c (address 8+2c) as code in bits 23:16, type in bits 14:12, method in bits 11:2, and zeros elsewhere. The data word goes to address 9+2c. Capture happens only when the channel's error flag is clear, or is being cleared in that same cycle, so the first error is kept.
- R5: A host write to record c replaces all 32 bits, so writing 0x90000000 reads back as 0x90000000. A capture in the same cycle takes precedence over the host write. Data words are read-only.
- R6: Status word 1 (address 1) bit 2+h is set by `vblank[h]` only while enable-word-1 bit 2+h is set. It is cleared by writing 1 to bit 2+h at address 1.
- R7: Address 4 sets the enable-word-1 bits written as ones, and address 5 clears them. All other enable bits are unchanged by these writes.
- R8: Status word 1 bits 6:4 hold the supervisor phase as a one-hot value, never more than one bit set. When no phase is pending after this cycle's clears, the lowest set bit of `sup_req` is latched. A request that arrives while a phase is still pending is dropped. Writing the phase bit back to address 1 clears it.
- R9: `irq` is high exactly when some status bit and its enable bit are both set. It goes low in the cycle after the write that clears the last such bit.
- R10: Considering only enabled pending bits, `svc_kind`/`svc_idx` select in this order:
  - errors: kind 1, index = lowest channel;
  - completions: kind 2, index = lowest channel;
  - vertical blank: kind 3, index = lowest head;
  - supervisor: kind 4, index = phase 0 to 2.
  With nothing pending, the kind is 0 and `svc_valid` is low.
- R11: The address map is:
  - 0: status word 0;
  - 1: status word 1;
  - 2: enable word 0, which keeps only bits 20:16 and 4:0;
  - 3: enable word 1, which keeps only bits 6:2; addresses 4 and 5 also read enable word 1;
  - 8 to 17: records and data words.
  Every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Host write strobe |
| reg_addr | input | AW (5) | Host word address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| ch_err | input | NCH (5) | Per-channel error event pulses |
| err_mthd | input | 10 | Method address of the error being reported |
| err_type | input | 3 | Error type (3 illegal method, 4 invalid value, 5 invalid state, 7 invalid handle) |
| err_code | input | 8 | Error code |
| err_data | input | 32 | Data word of the error |
| ch_done | input | NCH (5) | Per-channel completion event pulses |
| vblank | input | NHEAD (2) | Per-head vertical blank pulses |
| sup_req | input | 3 | Supervisor phase request |
| irq | output | 1 | Interrupt request |
| svc_valid | output | 1 | A source is selected for service |
| svc_kind | output | 3 | Selected source class |
| svc_idx | output | 4 | Channel, head or phase of the selected source |

## Verification
On every cycle, the assertions check four things: that the supervisor phase stays one-hot, that an error flag is held until it is explicitly cleared, that an error record does not change while its flag is pending, and that errors always win the service selection. They also check that a disabled head never records a vertical blank. The bench's scenarios are needed to show the field layout of a captured record, that the first error is kept, that a capture wins over a host write, and that a clear landing with a new supervisor request accepts the new phase. They also cover the enable set/clear aliases, and a long mixed random run that is compared against a behavioural model every cycle.

// File: rtl/disp_irq_ctrl.sv
module disp_irq_ctrl #(
  parameter int NCH   = 5,
  parameter int NHEAD = 2,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [NCH-1:0] ch_err,
  input  logic [9:0]    err_mthd,
  input  logic [2:0]    err_type,
  input  logic [7:0]    err_code,
  input  logic [31:0]   err_data,
  input  logic [NCH-1:0] ch_done,
  input  logic [NHEAD-1:0] vblank,
  input  logic [2:0]    sup_req,
  output logic          irq,
  output logic          svc_valid,
  output logic [2:0]    svc_kind,
  output logic [3:0]    svc_idx
);
  localparam int ERR_LSB = 16;
  localparam int VB_LSB  = 2;
  localparam int SUP_LSB = 4;
  localparam int A_REC   = 8;
  localparam logic [31:0] CH_ONES = (32'd1 << NCH) - 32'd1;
  localparam logic [31:0] M0 = (CH_ONES << ERR_LSB) | CH_ONES;
  localparam logic [31:0] M1 = (((32'd1 << NHEAD) - 32'd1) << VB_LSB) | (32'h7 << SUP_LSB);

  logic [NCH-1:0]   err_f, done_f;
  logic [NHEAD-1:0] vb_f;
  logic [2:0]       sup_f;
  logic [31:0]      en0, en1;
  logic [NCH-1:0][31:0] rec, dat;

  logic w0, w1;
  assign w0 = reg_we && (reg_addr == AW'(0));
  assign w1 = reg_we && (reg_addr == AW'(1));

  logic [NCH-1:0]   clr_err, clr_done;
  logic [NHEAD-1:0] clr_vb;
  logic [2:0]       clr_sup, sup_hold, sup_pick;
  assign clr_err  = w0 ? reg_wdata[ERR_LSB +: NCH] : '0;
  assign clr_done = w0 ? reg_wdata[0 +: NCH] : '0;
  assign clr_vb   = w1 ? reg_wdata[VB_LSB +: NHEAD] : '0;
  assign clr_sup  = w1 ? reg_wdata[SUP_LSB +: 3] : '0;
  assign sup_hold = sup_f & ~clr_sup;
  assign sup_pick = sup_req & (~sup_req + 3'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_f <= '0; done_f <= '0; vb_f <= '0; sup_f <= '0;
      en0 <= '0; en1 <= '0;
    end else begin
      err_f  <= (err_f & ~clr_err) | ch_err;
      done_f <= (done_f & ~clr_done) | ch_done;
      vb_f   <= (vb_f & ~clr_vb) | (vblank & en1[VB_LSB +: NHEAD]);
      sup_f  <= (sup_hold != 3'd0) ? sup_hold : sup_pick;
      if (reg_we) begin
        case (reg_addr)
          AW'(2): en0 <= reg_wdata & M0;
          AW'(3): en1 <= reg_wdata & M1;
          AW'(4): en1 <= en1 | (reg_wdata & M1);
          AW'(5): en1 <= en1 & ~reg_wdata;
          default: ;
        endcase
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_rec
    logic cap;
    assign cap = ch_err[c] && (!err_f[c] || clr_err[c]);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rec[c] <= '0;
        dat[c] <= '0;
      end else if (cap) begin
        rec[c] <= {8'h00, err_code, 1'b0, err_type, err_mthd, 2'b00};
        dat[c] <= err_data;
      end else if (reg_we && reg_addr == AW'(A_REC + 2*c)) begin
        rec[c] <= reg_wdata;
      end
    end
  end

  logic [31:0] s0, s1;
  assign s0 = (32'(err_f) << ERR_LSB) | 32'(done_f);
  assign s1 = (32'(vb_f) << VB_LSB) | (32'(sup_f) << SUP_LSB);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(0): reg_rdata = s0;
      AW'(1): reg_rdata = s1;
      AW'(2): reg_rdata = en0;
      AW'(3), AW'(4), AW'(5): reg_rdata = en1;
      default: ;
    endcase
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr == AW'(A_REC + 2*c))     reg_rdata = rec[c];
      if (reg_addr == AW'(A_REC + 2*c + 1)) reg_rdata = dat[c];
    end
  end

  logic [NCH-1:0]   pend_err, pend_done;
  logic [NHEAD-1:0] pend_vb;
  logic [2:0]       pend_sup;
  assign pend_err  = err_f & en0[ERR_LSB +: NCH];
  assign pend_done = done_f & en0[0 +: NCH];
  assign pend_vb   = vb_f & en1[VB_LSB +: NHEAD];
  assign pend_sup  = sup_f & en1[SUP_LSB +: 3];
  assign irq = |{pend_err, pend_done, pend_vb, pend_sup};

  always_comb begin
    svc_kind = 3'd0;
    svc_idx  = 4'd0;
    for (int p = 2; p >= 0; p--)
      if (pend_sup[p]) begin svc_kind = 3'd4; svc_idx = 4'(p); end
    for (int h = NHEAD-1; h >= 0; h--)
      if (pend_vb[h]) begin svc_kind = 3'd3; svc_idx = 4'(h); end
    for (int c = NCH-1; c >= 0; c--)
      if (pend_done[c]) begin svc_kind = 3'd2; svc_idx = 4'(c); end
    for (int c = NCH-1; c >= 0; c--)
      if (pend_err[c]) begin svc_kind = 3'd1; svc_idx = 4'(c); end
  end
  assign svc_valid = (svc_kind != 3'd0);
endmodule

// File: rtl/disp_irq_ctrl_chk.sv
module disp_irq_ctrl_chk #(
  parameter int NCH   = 5,
  parameter int NHEAD = 2,
  parameter int AW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [31:0]   reg_wdata,
  input logic [NCH-1:0] ch_err,
  input logic [NHEAD-1:0] vblank,
  input logic [NCH-1:0] err_f,
  input logic [NHEAD-1:0] vb_f,
  input logic [2:0]    sup_f,
  input logic [31:0]   en0,
  input logic [31:0]   en1,
  input logic [NCH-1:0][31:0] rec,
  input logic          irq,
  input logic          svc_valid,
  input logic [2:0]    svc_kind
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    p_err_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (err_f[c] && !(reg_we && reg_addr == AW'(0) && reg_wdata[16+c])) |=> err_f[c]);
    p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ch_err[c] |=> err_f[c]);
    p_rec_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (err_f[c] && !(reg_we && reg_addr == AW'(8 + 2*c))
                && !(reg_we && reg_addr == AW'(0) && reg_wdata[16+c])) |=> $stable(rec[c]));
  end
  for (genvar h = 0; h < NHEAD; h++) begin : g_hd
    p_vb_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!en1[2+h] && !vb_f[h]) |=> !vb_f[h]);
  end
  p_sup_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sup_f));
  p_irq_sel_r9: assert property (@(posedge clk) disable iff (!rst_n) irq == svc_valid);
  p_err_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(err_f & en0[16 +: NCH])) |-> svc_kind == 3'd1);
endmodule

bind disp_irq_ctrl disp_irq_ctrl_chk #(.NCH(NCH), .NHEAD(NHEAD), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .ch_err(ch_err), .vblank(vblank), .err_f(err_f), .vb_f(vb_f), .sup_f(sup_f),
  .en0(en0), .en1(en1), .rec(rec), .irq(irq), .svc_valid(svc_valid), .svc_kind(svc_kind)
);

// File: tb/sim_disp_irq_ctrl.sv
module sim_disp_irq_ctrl;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [4:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [4:0] ch_err = 0, ch_done = 0;
  logic [9:0] err_mthd = 0;
  logic [2:0] err_type = 0;
  logic [7:0] err_code = 0;
  logic [31:0] err_data = 0;
  logic [1:0] vblank = 0;
  logic [2:0] sup_req = 0;
  logic irq, svc_valid;
  logic [2:0] svc_kind;
  logic [3:0] svc_idx;

  always #5 clk = ~clk;

  disp_irq_ctrl u0 (.*);

  int checks = 0, errors = 0;
  bit finished = 0, live = 0;

  // behavioural reference
  bit m_err[5], m_done[5], m_vb[2];
  logic [2:0] m_sup;
  logic [31:0] m_en0, m_en1, m_rec[5], m_dat[5];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) begin m_err[i] = 0; m_done[i] = 0; m_rec[i] = 0; m_dat[i] = 0; end
      m_vb[0] = 0; m_vb[1] = 0; m_sup = 0; m_en0 = 0; m_en1 = 0;
    end else begin
      for (int c = 0; c < 5; c++) begin
        bit ce, cd;
        ce = reg_we && reg_addr == 0 && reg_wdata[16+c];
        cd = reg_we && reg_addr == 0 && reg_wdata[c];
        if (ch_err[c] && (!m_err[c] || ce)) begin
          m_rec[c] = {8'h00, err_code, 1'b0, err_type, err_mthd, 2'b00};
          m_dat[c] = err_data;
        end else if (reg_we && reg_addr == 8 + 2*c) m_rec[c] = reg_wdata;
        if (ch_err[c]) m_err[c] = 1; else if (ce) m_err[c] = 0;
        if (ch_done[c]) m_done[c] = 1; else if (cd) m_done[c] = 0;
      end
      for (int h = 0; h < 2; h++) begin
        if (vblank[h] && m_en1[2+h]) m_vb[h] = 1;
        else if (reg_we && reg_addr == 1 && reg_wdata[2+h]) m_vb[h] = 0;
      end
      if (reg_we && reg_addr == 1) m_sup = m_sup & ~reg_wdata[6:4];
      for (int p = 0; p < 3; p++)
        if (m_sup == 0 && sup_req[p]) m_sup = 3'(1 << p);
      if (reg_we) begin
        if (reg_addr == 2) m_en0 = reg_wdata & 32'h001F001F;
        if (reg_addr == 3) m_en1 = reg_wdata & 32'h7C;
        if (reg_addr == 4) m_en1 = m_en1 | (reg_wdata & 32'h7C);
        if (reg_addr == 5) m_en1 = m_en1 & ~reg_wdata;
      end
    end
  end

  function automatic logic [31:0] exp_rd(int a);
    logic [31:0] v = 0;
    if (a == 0) for (int c = 0; c < 5; c++) begin v[16+c] = m_err[c]; v[c] = m_done[c]; end
    if (a == 1) begin v[2] = m_vb[0]; v[3] = m_vb[1]; v[6:4] = m_sup; end
    if (a == 2) v = m_en0;
    if (a >= 3 && a <= 5) v = m_en1;
    if (a >= 8 && a <= 17) v = (a % 2 == 0) ? m_rec[(a-8)/2] : m_dat[(a-8)/2];
    return v;
  endfunction

  function automatic string rtag(int a);
    if (a == 0) return "R2";
    if (a == 1) return "R6/R8";
    if (a >= 3 && a <= 5) return "R7";
    if (a >= 8 && a <= 17) return "R4";
    return "R11";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int k = 0, ix = 0;
    bit any = 0;
    for (int c = 0; c < 5; c++) if (k == 0 && m_err[c] && m_en0[16+c]) begin k = 1; ix = c; end
    for (int c = 0; c < 5; c++) if (k == 0 && m_done[c] && m_en0[c]) begin k = 2; ix = c; end
    for (int h = 0; h < 2; h++) if (k == 0 && m_vb[h] && m_en1[2+h]) begin k = 3; ix = h; end
    for (int p = 0; p < 3; p++) if (k == 0 && m_sup[p] && m_en1[4+p]) begin k = 4; ix = p; end
    any = (k != 0);
    chk(rtag(int'(reg_addr)), reg_rdata, exp_rd(int'(reg_addr)));
    chk("R9 irq", 32'(irq), 32'(any));
    chk("R10 kind", 32'(svc_kind), 32'(k));
    chk("R10 valid", 32'(svc_valid), 32'(any));
    if (k != 0) chk("R10 idx", 32'(svc_idx), 32'(ix));
  endtask

  task automatic tick();
    #1;
    if (live) compare_all();
    @(posedge clk);
    @(negedge clk);
    reg_we = 0; ch_err = 0; ch_done = 0; vblank = 0; sup_req = 0;
  endtask

  task automatic wr(int a, logic [31:0] d);
    reg_we = 1; reg_addr = 5'(a); reg_wdata = d;
    tick();
  endtask

  task automatic peek(int a, logic [31:0] e, string tag);
    reg_we = 0; reg_addr = 5'(a);
    #1 chk(tag, reg_rdata, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    live = 1;
    peek(0, 0, "R1 stat0"); chk("R1 irq", 32'(irq), 0);
    peek(2, 0, "R1 en0"); peek(14, 0, "R1 rec");
    wr(2, 32'hFFFFFFFF);
    peek(2, 32'h001F001F, "R11 en0 mask"); peek(6, 0, "R11 unmapped");
    err_mthd = 10'h123; err_type = 5; err_code = 8'hA5; err_data = 32'hDEADBEEF;
    ch_err = 5'b01000; tick();
    peek(0, 32'h00080000, "R2 err flag");
    peek(14, 32'h00A5548C, "R4 record");
    peek(15, 32'hDEADBEEF, "R4 data");
    chk("R10 kind err", 32'(svc_kind), 1); chk("R10 idx ch3", 32'(svc_idx), 3);
    chk("R9 irq up", 32'(irq), 1);
    err_mthd = 10'h3FF; err_type = 3; err_code = 8'h01; err_data = 0;
    ch_err = 5'b01000; tick();
    peek(14, 32'h00A5548C, "R4 first kept");
    err_mthd = 0; err_type = 7; err_code = 0; err_data = 1;
    ch_err = 5'b00010; tick();
    chk("R10 lowest ch", 32'(svc_idx), 1);
    peek(10, 32'h00007000, "R4 type field");
    wr(14, 32'h90000000);
    peek(14, 32'h90000000, "R5 host write");
    wr(0, 32'h000A0000);
    peek(0, 0, "R2 cleared"); chk("R9 irq down", 32'(irq), 0);
    ch_done = 5'b00100; tick();
    reg_we = 1; reg_addr = 0; reg_wdata = 32'h4; ch_done = 5'b00100; tick();
    peek(0, 32'h4, "R3 set wins");
    wr(0, 32'h4);
    peek(0, 0, "R2 done cleared"); chk("R9 irq down2", 32'(irq), 0);
    vblank = 2'b01; tick();
    peek(1, 0, "R6 gated");
    wr(4, 32'h4); peek(3, 32'h4, "R7 set alias");
    vblank = 2'b01; tick();
    peek(1, 32'h4, "R6 recorded");
    chk("R9 irq vb", 32'(irq), 1);
    chk("R10 kind vb", 32'(svc_kind), 3); chk("R10 idx vb", 32'(svc_idx), 0);
    wr(1, 32'h4); peek(1, 0, "R6 cleared");
    wr(4, 32'h70); peek(3, 32'h74, "R7 set keeps");
    wr(5, 32'h4); peek(3, 32'h70, "R7 clear keeps");
    sup_req = 3'b110; tick();
    peek(1, 32'h20, "R8 lowest phase");
    chk("R10 kind sup", 32'(svc_kind), 4); chk("R10 idx sup", 32'(svc_idx), 1);
    sup_req = 3'b001; tick();
    peek(1, 32'h20, "R8 dropped");
    reg_we = 1; reg_addr = 1; reg_wdata = 32'h20; sup_req = 3'b100; tick();
    peek(1, 32'h40, "R8 clear and accept");
    wr(1, 32'h40); peek(1, 0, "R8 cleared"); chk("R9 irq down3", 32'(irq), 0);
    err_mthd = 10'h001; err_type = 4; err_code = 8'h10; err_data = 32'h55;
    reg_we = 1; reg_addr = 10; reg_wdata = 32'h12345678; ch_err = 5'b00010; tick();
    peek(10, 32'h00104004, "R5 capture wins");
    wr(0, 32'h00020000);
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 6 == 0) ch_err = 5'($urandom);
      if ($urandom % 5 == 0) ch_done = 5'($urandom);
      if ($urandom % 4 == 0) vblank = 2'($urandom);
      if ($urandom % 7 == 0) sup_req = 3'($urandom);
      err_mthd = 10'($urandom); err_type = 3'($urandom); err_code = 8'($urandom); err_data = $urandom;
      reg_addr = 5'($urandom % 20);
      reg_we = ($urandom % 3 == 0);
      reg_wdata = ($urandom % 2) ? $urandom : 32'hFFFFFFFF;
      tick();
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule